// File: doc/BRIEF.md
# Segment Lookaside Buffer Unit

This block keeps a small, fully associative table of segment descriptors that a memory management unit consults before any page-table walk. Each slot holds two 64-bit words: an effective-segment word, which carries the segment number and a valid flag, and a virtual-segment word, which carries the segment size, the virtual segment number, the protection keys, a no-execute flag, a class flag and a page-size code. An associative lookup compares an effective address against every slot at once. Two segment sizes, 256 MB and 1 TB, are matched in the same lookup.

Software-style commands maintain the table. A checked write fills a slot. Slot-indexed reads return either word. A single-entry invalidate removes the slot that an address hits. A bulk invalidate takes a 3-bit mode that selects which slots it clears. A one-cycle command handshake accepts each command, and the response comes back one cycle later. The response carries an error flag, a warning flag and the pulses that ask the downstream translation cache to flush.

Top module: `slb_unit`

## Requirements
- R1: While reset is held, cmd_ready is 0. After reset every slot is invalid: rsp_valid is 0 and a lookup misses.
- R2: A lookup hits a slot when the slot's size field (vsid bits 63:62) is 00 (256 MB) and its stored effective word equals {ea[63:28], 1, 27 zero bits}. On a hit rsp_data is that slot's virtual word and rsp_index is the slot number.
- R3: A lookup hits a slot when the size field is 01 (1 TB) and the stored effective word equals {ea[63:40], 12 zero bits, 1, 27 zero bits}. A 1 TB slot therefore ignores address bits 39:28.
- R4: When several slots hit, the lowest-numbered slot is returned.
- R5: A lookup that misses returns rsp_hit 0 and rsp_data all ones. When cmd_narrow is 1, the lookup address is cut to its low 32 bits first.
- R6: A write (operand in cmd_addr: slot in bits 11:0, segment number in 63:28, valid in bit 27; cmd_data is the virtual word) sets rsp_err and leaves the table unchanged in each of these cases: the slot is at or above the entry count; any of bits 26:12 is set; the size field is 1x; the size is 1 TB and 1 TB support is off; or the page-size code {vsid[8], vsid[5:4]} is not enabled in the legal-code mask (default codes 0, 4, 5 and 7). An accepted write stores the operand with bits 11:0 cleared.
- R7: A read of the effective word (op 2) or the virtual word (op 3) takes the slot from cmd_addr[11:0]. A slot out of range gives rsp_err 1 and rsp_data 0.
- R8: A bulk invalidate in mode 0, 1, 2 or 6 clears the valid bit of every slot except slot 0.
- R9: Modes 3 and 4 include slot 0. Mode 3 keeps every slot whose class bit (vsid bit 7) is 0.
- R10: Mode 7 clears nothing. Mode 5 acts like mode 0 and raises rsp_warn.
- R11: Every bulk invalidate pulses flush_local with its response, whether or not any slot changed.
- R12: A single-entry invalidate (op 4) clears the slot its address hits (256 MB/1 TB rules, lowest first) and pulses flush_global if cmd_global is 1, otherwise flush_local. On a miss it changes nothing and pulses no flush.
- R13: A command is accepted in a cycle with cmd_valid and cmd_ready high. The registered response has rsp_valid high for exactly the next cycle. Ops 0 to 5 are lookup, write, read effective word, read virtual word, single invalidate and bulk invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 64 | Effective address or slot operand |
| cmd_data | input | 64 | Virtual word for writes |
| cmd_mode | input | 3 | Bulk invalidate mode |
| cmd_global | input | 1 | Single invalidate requests global flush |
| cmd_narrow | input | 1 | Lookup uses low 32 address bits |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Looked-up or read word |
| rsp_hit | output | 1 | Lookup or single invalidate hit |
| rsp_index | output | IW | Hit slot number |
| rsp_err | output | 1 | Command rejected |
| rsp_warn | output | 1 | Undefined bulk mode used |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |

## Verification
Lookups are tried with addresses inside a 256 MB segment and inside a 1 TB segment. They are also tried with an address that differs only in bits 39:28, which separates the two compare widths, and with a wide address that hits only after 32-bit truncation. Two slots hold the same segment, so the priority order shows both before and after the lower slot is invalidated. Each bulk mode family runs on a table that mixes slot 0 with slots whose class bit is 1 and slots whose class bit is 0, which separates skipping slot 0, filtering by class and doing nothing. Rejected writes are followed by reads of the targeted slot to show that it stayed empty.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'd0,
        OP_WRITE   = 3'd1,
        OP_RD_ESID = 3'd2,
        OP_RD_VSID = 3'd3,
        OP_INV_ONE = 3'd4,
        OP_INV_ALL = 3'd5
    } slb_op_e;

    // effective word layout
    localparam int SEG_LO   = 28;
    localparam int SEG1T_LO = 40;
    localparam int VAL_BIT  = 27;
    localparam int RSV_HI   = 26;
    localparam int RSV_LO   = 12;
    localparam int SLOT_W   = 12;
    // virtual word layout
    localparam int SZ_HI    = 63;
    localparam int SZ_LO    = 62;
    localparam int L_BIT    = 8;
    localparam int C_BIT    = 7;
    localparam int LP_HI    = 5;
    localparam int LP_LO    = 4;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    typedef struct packed {
        logic [63:0] esid;
        logic [63:0] vsid;
    } slb_entry_t;

    function automatic logic [63:0] key_256m(input logic [35:0] seg);
        return {seg, 1'b1, 27'd0};
    endfunction

    function automatic logic [63:0] key_1t(input logic [23:0] seg);
        return {seg, 12'd0, 1'b1, 27'd0};
    endfunction

    // does a bulk invalidate of this mode drop a slot?
    function automatic logic bulk_drops(input logic [2:0] mode,
                                        input logic is_zero,
                                        input logic cls);
        case (mode)
            3'd7:    return 1'b0;
            3'd3:    return cls;
            3'd4:    return 1'b1;
            default: return !is_zero;
        endcase
    endfunction

endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  slb_entry_t      ent [N],
    input  logic [35:0]     seg,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    logic [N-1:0] mv;
    logic [63:0]  k256;
    logic [63:0]  k1t;

    assign k256 = key_256m(seg);
    assign k1t  = key_1t(seg[35:12]);

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign mv[gi] =
            ((ent[gi].esid == k256) && (ent[gi].vsid[SZ_HI:SZ_LO] == SZ_256M)) ||
            ((ent[gi].esid == k1t)  && (ent[gi].vsid[SZ_HI:SZ_LO] == SZ_1T));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mv[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int         N         = 64,
    parameter bit         HAS_1T    = 1'b1,
    parameter logic [7:0] LEGAL_PSZ = 8'b1011_0001
) (
    input  logic [SLOT_W-1:0]    slot,
    input  logic [RSV_HI:RSV_LO] rsv,
    input  logic [1:0]           size,
    input  logic [2:0]           psz,
    output logic                 err
);
    logic bad_slot, bad_rsv, bad_size, bad_1t, bad_psz;

    always_comb begin
        bad_slot = int'(slot) >= N;
        bad_rsv  = |rsv;
        bad_size = size[1];
        bad_1t   = size[0] && !HAS_1T;
        bad_psz  = !LEGAL_PSZ[psz];
        err      = bad_slot | bad_rsv | bad_size | bad_1t | bad_psz;
    end
endmodule

// File: rtl/slb_store.sv
module slb_store
    import slb_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  slb_entry_t      wr_ent,
    input  logic            one_en,
    input  logic [IW-1:0]   one_idx,
    input  logic            bulk_en,
    input  logic [2:0]      bulk_mode,
    output slb_entry_t      ent [N]
);
    for (genvar gi = 0; gi < N; gi++) begin : g_slot
        logic drop;
        assign drop = (one_en && (one_idx == IW'(gi))) ||
                      (bulk_en && bulk_drops(bulk_mode, gi == 0, ent[gi].vsid[C_BIT]));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent[gi] <= '0;
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                ent[gi] <= wr_ent;
            end else if (drop) begin
                ent[gi].esid[VAL_BIT] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slb_unit.sv
module slb_unit
    import slb_pkg::*;
#(
    parameter int         N         = 64,
    parameter bit         HAS_1T    = 1'b1,
    parameter logic [7:0] LEGAL_PSZ = 8'b1011_0001,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [2:0]      cmd_op,
    input  logic [63:0]     cmd_addr,
    input  logic [63:0]     cmd_data,
    input  logic [2:0]      cmd_mode,
    input  logic            cmd_global,
    input  logic            cmd_narrow,
    output logic            rsp_valid,
    output logic [63:0]     rsp_data,
    output logic            rsp_hit,
    output logic [IW-1:0]   rsp_index,
    output logic            rsp_err,
    output logic            rsp_warn,
    output logic            flush_local,
    output logic            flush_global
);
    slb_entry_t        ent [N];
    logic              accept;
    logic [35:0]       lk_seg;
    logic              hit;
    logic [IW-1:0]     hit_idx;
    logic              wr_err;
    logic [SLOT_W-1:0] slot;
    logic              slot_ok;
    logic [IW-1:0]     sidx;
    slb_entry_t        wr_ent;

    logic [63:0]   n_data;
    logic          n_hit, n_err, n_warn, n_fl, n_fg;

    assign cmd_ready = !rst;
    assign accept    = cmd_valid && cmd_ready;
    assign slot      = cmd_addr[SLOT_W-1:0];
    assign slot_ok   = int'(slot) < N;
    assign sidx      = slot[IW-1:0];
    assign lk_seg    = (cmd_op == OP_LOOKUP && cmd_narrow) ?
                       {32'd0, cmd_addr[31:SEG_LO]} : cmd_addr[63:SEG_LO];
    assign wr_ent    = '{esid: {cmd_addr[63:SLOT_W], {SLOT_W{1'b0}}}, vsid: cmd_data};

    slb_match #(.N(N)) u_match (
        .ent (ent),
        .seg (lk_seg),
        .hit (hit),
        .idx (hit_idx)
    );

    slb_wr_check #(.N(N), .HAS_1T(HAS_1T), .LEGAL_PSZ(LEGAL_PSZ)) u_wchk (
        .slot (slot),
        .rsv  (cmd_addr[RSV_HI:RSV_LO]),
        .size (cmd_data[SZ_HI:SZ_LO]),
        .psz  ({cmd_data[L_BIT], cmd_data[LP_HI:LP_LO]}),
        .err  (wr_err)
    );

    slb_store #(.N(N)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept && cmd_op == OP_WRITE && !wr_err),
        .wr_idx    (sidx),
        .wr_ent    (wr_ent),
        .one_en    (accept && cmd_op == OP_INV_ONE && hit),
        .one_idx   (hit_idx),
        .bulk_en   (accept && cmd_op == OP_INV_ALL),
        .bulk_mode (cmd_mode),
        .ent       (ent)
    );

    always_comb begin
        n_data = '0;
        n_hit  = 1'b0;
        n_err  = 1'b0;
        n_warn = 1'b0;
        n_fl   = 1'b0;
        n_fg   = 1'b0;
        case (cmd_op)
            OP_LOOKUP: begin
                n_hit  = hit;
                n_data = hit ? ent[hit_idx].vsid : '1;
            end
            OP_WRITE:   n_err = wr_err;
            OP_RD_ESID: begin
                n_err  = !slot_ok;
                n_data = slot_ok ? ent[sidx].esid : '0;
            end
            OP_RD_VSID: begin
                n_err  = !slot_ok;
                n_data = slot_ok ? ent[sidx].vsid : '0;
            end
            OP_INV_ONE: begin
                n_hit = hit;
                n_fl  = hit && !cmd_global;
                n_fg  = hit && cmd_global;
            end
            OP_INV_ALL: begin
                n_fl   = 1'b1;
                n_warn = (cmd_mode == 3'd5);
            end
            default: n_err = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_hit      <= 1'b0;
            rsp_index    <= '0;
            rsp_err      <= 1'b0;
            rsp_warn     <= 1'b0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            rsp_valid    <= accept;
            rsp_data     <= accept ? n_data : '0;
            rsp_hit      <= accept && n_hit;
            rsp_index    <= (accept && n_hit) ? hit_idx : '0;
            rsp_err      <= accept && n_err;
            rsp_warn     <= accept && n_warn;
            flush_local  <= accept && n_fl;
            flush_global <= accept && n_fg;
        end
    end
endmodule

// File: rtl/slb_unit_chk.sv
module slb_unit_chk
    import slb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [2:0]  cmd_op,
    input logic [2:0]  cmd_mode,
    input logic        cmd_global,
    input logic        rsp_valid,
    input logic [63:0] rsp_data,
    input logic        rsp_hit,
    input logic        rsp_err,
    input logic        rsp_warn,
    input logic        flush_local,
    input logic        flush_global
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_rsp_next_r13: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    p_rsp_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);

    p_bulk_flush_r11: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_INV_ALL) |=> flush_local);

    p_miss_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_LOOKUP) |=> (rsp_hit || rsp_data == '1));

    p_inv_miss_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_INV_ONE) |=> (rsp_hit || (!flush_local && !flush_global)));

    p_local_only_r12: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_INV_ONE && !cmd_global) |=> !flush_global);

    p_warn_mode5_r10: assert property (@(posedge clk) disable iff (rst)
        (acc && !(cmd_op == OP_INV_ALL && cmd_mode == 3'd5)) |=> !rsp_warn);

    p_err_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !rsp_hit);

    p_ready_reset_r1: assert property (@(posedge clk)
        rst |-> !cmd_ready);
endmodule

bind slb_unit slb_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_mode     (cmd_mode),
    .cmd_global   (cmd_global),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_hit      (rsp_hit),
    .rsp_err      (rsp_err),
    .rsp_warn     (rsp_warn),
    .flush_local  (flush_local),
    .flush_global (flush_global)
);

// File: tb/slb_unit_tb.sv
module slb_unit_tb;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic [2:0]  cmd_mode = '0;
    logic cmd_global = 1'b0;
    logic cmd_narrow = 1'b0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic rsp_hit;
    logic [IW-1:0] rsp_index;
    logic rsp_err, rsp_warn, flush_local, flush_global;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    slb_unit u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_mode(cmd_mode), .cmd_global(cmd_global), .cmd_narrow(cmd_narrow),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .rsp_index(rsp_index), .rsp_err(rsp_err), .rsp_warn(rsp_warn),
        .flush_local(flush_local), .flush_global(flush_global)
    );

    localparam logic [2:0] LK = 3'd0, WR = 3'd1, RE = 3'd2, RV = 3'd3,
                           IO = 3'd4, IA = 3'd5;

    localparam logic [63:0] A_RB = 64'h0000_0001_2800_0002;
    localparam logic [63:0] A_VS = 64'h0000_0000_00AB_C080;
    localparam logic [63:0] B_RB = 64'h0000_0300_0800_0005;
    localparam logic [63:0] B_VS = 64'h4000_0000_0012_3100;
    localparam logic [63:0] C_RB = 64'h0000_0000_5800_0000;
    localparam logic [63:0] C_VS = 64'h0000_0000_0077_7080;
    localparam logic [63:0] D_RB = 64'h0000_0001_2800_0009;
    localparam logic [63:0] D_VS = 64'h0000_0000_00DD_D110;
    localparam logic [63:0] A_EA = 64'h0000_0001_2345_6789;
    localparam logic [63:0] B_EA = 64'h0000_0302_3456_7890;
    localparam logic [63:0] C_EA = 64'hFFFF_FFFF_5000_1234;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [3:0]  tg;
        logic [2:0]  op;
        logic [63:0] a;
        logic [63:0] d;
        logic        nar;
        logic        e_err;
        logic        e_hit;
        logic [63:0] e_data;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd6,  WR, A_RB, A_VS, 1'b0, 1'b0, 1'b0, 64'd0},   // R6 accepted write
        '{4'd6,  WR, B_RB, B_VS, 1'b0, 1'b0, 1'b0, 64'd0},
        '{4'd6,  WR, C_RB, C_VS, 1'b0, 1'b0, 1'b0, 64'd0},
        '{4'd6,  WR, D_RB, D_VS, 1'b0, 1'b0, 1'b0, 64'd0},
        '{4'd4,  LK, A_EA, 64'd0, 1'b0, 1'b0, 1'b1, A_VS},  // R2 R4 slot 2 beats 9
        '{4'd3,  LK, B_EA, 64'd0, 1'b0, 1'b0, 1'b1, B_VS},  // R3 1 TB hit
        '{4'd3,  LK, 64'h0000_0001_3000_0000, 64'd0, 1'b0, 1'b0, 1'b0, ONES}, // R3 R5
        '{4'd5,  LK, C_EA, 64'd0, 1'b1, 1'b0, 1'b1, C_VS},  // R5 narrow
        '{4'd5,  LK, C_EA, 64'd0, 1'b0, 1'b0, 1'b0, ONES},  // R5 wide miss
        '{4'd6,  WR, 64'h0000_0001_2800_0040, A_VS, 1'b0, 1'b1, 1'b0, 64'd0},
        '{4'd6,  WR, 64'h0000_0001_2800_1003, A_VS, 1'b0, 1'b1, 1'b0, 64'd0},
        '{4'd6,  WR, 64'h0000_0001_2800_0003, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0, 64'd0},
        '{4'd6,  WR, 64'h0000_0001_2800_0003, 64'h0000_0000_0000_0010, 1'b0, 1'b1, 1'b0, 64'd0},
        '{4'd6,  RE, 64'h0000_0000_0000_0003, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0}, // R6 slot 3 untouched
        '{4'd7,  RE, 64'h0000_0000_0000_0002, 64'd0, 1'b0, 1'b0, 1'b0, 64'h0000_0001_2800_0000},
        '{4'd7,  RV, 64'h0000_0000_0000_0005, 64'd0, 1'b0, 1'b0, 1'b0, B_VS},
        '{4'd7,  RV, 64'h0000_0000_0000_0040, 64'd0, 1'b0, 1'b1, 1'b0, 64'd0}, // R7
        '{4'd7,  RE, 64'h0000_0000_0000_0FFF, 64'd0, 1'b0, 1'b1, 1'b0, 64'd0}
    };

    task automatic chk(input int tg, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", tg, what, got, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d,
                       input logic [2:0] m, input logic g, input logic nar);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_addr   = a;
        cmd_data   = d;
        cmd_mode   = m;
        cmd_global = g;
        cmd_narrow = nar;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic lookup(input int tg, input logic [63:0] ea, input logic e_hit,
                          input logic [63:0] e_data);
        run(LK, ea, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(tg, "lookup hit", {63'd0, rsp_hit}, {63'd0, e_hit});
        chk(tg, "lookup data", rsp_data, e_data);
    endtask

    task automatic bulk(input int tg, input logic [2:0] m, input logic e_warn);
        run(IA, 64'd0, 64'd0, m, 1'b0, 1'b0);
        chk(11, "bulk flush_local", {63'd0, flush_local}, 64'd1);   // R11
        chk(tg, "bulk warn", {63'd0, rsp_warn}, {63'd0, e_warn});
    endtask

    initial begin
        #(20 * 20000);
        $display("FAIL R13 watchdog expired: got hang expected finish");
        fails++;
        checks++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        chk(1, "ready in reset", {63'd0, cmd_ready}, 64'd0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(1, "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk(1, "ready after reset", {63'd0, cmd_ready}, 64'd1);
        lookup(1, 64'd0, 1'b0, ONES);
        lookup(1, B_EA, 1'b0, ONES);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].op, VEC[i].a, VEC[i].d, 3'd0, 1'b0, VEC[i].nar);
            chk(13, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
            chk(int'(VEC[i].tg), "err", {63'd0, rsp_err}, {63'd0, VEC[i].e_err});
            chk(int'(VEC[i].tg), "hit", {63'd0, rsp_hit}, {63'd0, VEC[i].e_hit});
            chk(int'(VEC[i].tg), "data", rsp_data, VEC[i].e_data);
        end

        // R13: response lasts one cycle
        @(negedge clk);
        chk(13, "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);

        // R3 index of 1 TB hit
        run(LK, B_EA, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(3, "index 1TB", {58'd0, rsp_index}, 64'd5);

        // R12 single invalidate, global
        run(IO, 64'h0000_0001_2000_0000, 64'd0, 3'd0, 1'b1, 1'b0);
        chk(12, "inv hit", {63'd0, rsp_hit}, 64'd1);
        chk(12, "inv global flush", {63'd0, flush_global}, 64'd1);
        chk(12, "inv no local flush", {63'd0, flush_local}, 64'd0);
        // R4 next slot now wins
        run(LK, 64'h0000_0001_2000_0000, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(4, "second copy data", rsp_data, D_VS);
        chk(4, "second copy index", {58'd0, rsp_index}, 64'd9);
        // R12 local
        run(IO, 64'h0000_0001_2000_0000, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(12, "inv local flush", {63'd0, flush_local}, 64'd1);
        chk(12, "inv local not global", {63'd0, flush_global}, 64'd0);
        // R12 miss
        run(IO, 64'h0000_0001_2000_0000, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(12, "inv miss hit", {63'd0, rsp_hit}, 64'd0);
        chk(12, "inv miss no flush", {62'd0, flush_local, flush_global}, 64'd0);
        @(negedge clk);
        chk(13, "flush pulse ends", {63'd0, flush_local}, 64'd0);

        // R10 mode 7
        run(WR, A_RB, A_VS, 3'd0, 1'b0, 1'b0);
        bulk(10, 3'd7, 1'b0);
        lookup(10, A_EA, 1'b1, A_VS);
        lookup(10, B_EA, 1'b1, B_VS);
        // R10 mode 5, R8 slot 0 kept
        bulk(10, 3'd5, 1'b1);
        lookup(10, A_EA, 1'b0, ONES);
        lookup(8, 64'h0000_0000_5000_1234, 1'b1, C_VS);
        // R9 mode 3
        run(WR, A_RB, A_VS, 3'd0, 1'b0, 1'b0);
        run(WR, B_RB, B_VS, 3'd0, 1'b0, 1'b0);
        bulk(9, 3'd3, 1'b0);
        lookup(9, A_EA, 1'b0, ONES);
        lookup(9, B_EA, 1'b1, B_VS);
        lookup(9, 64'h0000_0000_5000_1234, 1'b0, ONES);
        // R9 mode 4
        run(WR, C_RB, C_VS, 3'd0, 1'b0, 1'b0);
        bulk(9, 3'd4, 1'b0);
        run(RE, 64'd0, 64'd0, 3'd0, 1'b0, 1'b0);
        chk(9, "slot0 valid cleared", rsp_data, 64'h0000_0000_5000_0000);
        lookup(9, B_EA, 1'b0, ONES);
        // R8 mode 6 and mode 0
        run(WR, C_RB, C_VS, 3'd0, 1'b0, 1'b0);
        run(WR, A_RB, A_VS, 3'd0, 1'b0, 1'b0);
        bulk(8, 3'd6, 1'b0);
        lookup(8, A_EA, 1'b0, ONES);
        lookup(8, 64'h0000_0000_5000_1234, 1'b1, C_VS);
        run(WR, A_RB, A_VS, 3'd0, 1'b0, 1'b0);
        bulk(8, 3'd0, 1'b0);
        lookup(8, A_EA, 1'b0, ONES);
        lookup(8, 64'h0000_0000_5000_1234, 1'b1, C_VS);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule